// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

A 16-bit up-counter for a microcontroller-style peripheral set. A two-bit select picks the count clock from four sources: system clock divided by four, the raw system clock, an external pin, and an auxiliary sensing input. The counter then divides that clock by 1, 2, 4 or 8 before it advances. Everything runs on the single system clock. The external and auxiliary inputs are reduced to rising-edge enables, and the count clock never becomes a second clock domain.

Counting is qualified by a programmable gate. A two-bit select picks one of four gate sources, and a polarity bit can invert it. Two further bits set how the gate is used. In toggle mode the window opens and closes on alternate gate edges, so one full period is measured. In single-pulse mode software arms a go bit, exactly one gate window is counted, and the hardware then drops the go bit. Both modes may be enabled together.

The block reports the live gate level, a sticky overflow flag and a sticky gate-event flag. Software loads the count one byte at a time, writes two configuration bytes, and clears each flag with its own pulse.

Top module: `gated_timer16`

## Requirements
- R1: A write to address 0 loads count bits [7:0] and a write to address 1 loads bits [15:8]; in that cycle the count does not increment, and the prescaler phase is reset to zero. Otherwise the count changes only by +1 on a prescaled tick.
- R2: Control byte (address 2) bits [2:1] select the count clock: 0 = every fourth system clock, 1 = every system clock, 2 = each rising edge of `ext_clk_i`, 3 = each rising edge of `aux_clk_i`.
- R3: Control byte bits [4:3] = p divide the selected clock by 2^p. The count advances once every 2^p enabled source ticks.
- R4: Counting takes place only while control bit 0 (module on) is 1, and either gate byte bit 0 (gate enable) is 0 or the gate window is open.
- R5: A roll-over from 0xFFFF to 0x0000 sets `ovf_flag_o`. The flag holds until `ovf_clr_i` is pulsed, and a set in the same cycle wins.
- R6: Gate byte (address 3) bits [6:5] select `gate_src_i[index]`. Bit 1 = 1 opens the gate while the source is high, and 0 opens it while the source is low. `gate_level_o` is this adjusted level, registered one cycle after the source.
- R7: Gate byte bit 2 (toggle) makes the window flip on every rising edge of the adjusted level. The toggle state is cleared while the module is off.
- R8: Gate byte bit 3 (single pulse) with bit 4 (go, readable on `go_o`): after go is set, the window opens on the next rising edge of the gate signal and closes on its following falling edge. The hardware then clears go, and no further window opens until go is written again.
- R9: With gate enable set, a falling edge of the gate signal sets `gate_flag_o`. In single-pulse mode this happens only at the end of an armed window. The flag holds until `gate_flag_clr_i` is pulsed.
- R10: Reset (`rst_ni` low) clears the count, all configuration, both flags and go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 count low, 1 count high, 2 control, 3 gate |
| wr_data_i | input | 8 | Write data |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| gate_flag_clr_i | input | 1 | Clears the gate-event flag |
| ext_clk_i | input | 1 | External count clock |
| aux_clk_i | input | 1 | Auxiliary sensing count clock |
| gate_src_i | input | 4 | Gate sources: pin, timer overflow, period match, watchdog overflow |
| count_o | output | 16 | Current count |
| gate_level_o | output | 1 | Polarity-adjusted gate level |
| go_o | output | 1 | Single-pulse go/done bit |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| gate_flag_o | output | 1 | Sticky gate-event flag |

## Verification
The bench loads the count just below 0xFFFF. If the wrap or the flag were wrong, the count would stop or the flag would stay low. It also changes the prescale ratio while the counter runs, where a prescaler compared only for equality would stall for a full wrap. In toggle mode it checks that switching the module off discards a half-open window; a design that kept the toggle state would count straight away after restart. In single-pulse mode it gives a second gate pulse after completion, and a design that did not clear go would count that pulse as well.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int PS_W   = 2;
  localparam int GSEL_W = 2;
  localparam int NSRC   = 1 << GSEL_W;

  localparam logic [1:0] A_CNT_LO = 2'd0;
  localparam logic [1:0] A_CNT_HI = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_GATE   = 2'd3;

  typedef enum logic [1:0] {
    CK_INSTR = 2'd0,
    CK_SYS   = 2'd1,
    CK_EXT   = 2'd2,
    CK_AUX   = 2'd3
  } clk_sel_e;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    clk_sel_e        csel;
    logic            on;
  } ctrl_t;

  typedef struct packed {
    logic [GSEL_W-1:0] src;
    logic              go;
    logic              spm;
    logic              tgl;
    logic              pol;
    logic              en;
  } gate_cfg_t;
endpackage

// File: rtl/gt_tick_gen.sv
module gt_tick_gen
  import gt_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_sel_e sel_i,
  input  logic     ext_clk_i,
  input  logic     aux_clk_i,
  output logic     tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             ext_q, aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ext_q <= 1'b0;
      aux_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      ext_q <= ext_clk_i;
      aux_q <= aux_clk_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      CK_INSTR: tick_o = &div_q;
      CK_SYS:   tick_o = 1'b1;
      CK_EXT:   tick_o = ext_clk_i & ~ext_q;
      default:  tick_o = aux_clk_i & ~aux_q;
    endcase
  end
endmodule

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PS_W-1:0] ps_i,
  input  logic            tick_i,
  input  logic            en_i,
  input  logic            clr_i,
  output logic            inc_o
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pcnt_q, lim;

  always_comb begin
    for (int i = 0; i < PC_W; i++) lim[i] = (i < int'(ps_i));
  end

  // >= so a ratio lowered mid-count does not stall
  assign inc_o = tick_i & en_i & (pcnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (clr_i)             pcnt_q <= '0;
    else if (tick_i && en_i)    pcnt_q <= inc_o ? '0 : pcnt_q + 1'b1;
  end

  // R3
  pcnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tick_i && en_i) && !clr_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/gt_gate.sv
module gt_gate
  import gt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  gate_cfg_t       cfg_i,
  input  logic            on_i,
  output logic            level_o,
  output logic            open_o,
  output logic            event_o,
  output logic            done_o
);
  logic lvl_q, lvl_d_q, tff_q, m_q, sp_act_q;
  logic raw, m, rise, fall, sp_act_d;

  assign raw  = src_i[cfg_i.src];
  assign m    = cfg_i.tgl ? tff_q : lvl_q;
  assign rise = m & ~m_q;
  assign fall = ~m & m_q;

  always_comb begin
    if (!cfg_i.spm || !cfg_i.go) sp_act_d = 1'b0;
    else if (sp_act_q && fall)   sp_act_d = 1'b0;
    else if (rise)               sp_act_d = 1'b1;
    else                         sp_act_d = sp_act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      lvl_d_q  <= 1'b0;
      tff_q    <= 1'b0;
      m_q      <= 1'b0;
      sp_act_q <= 1'b0;
    end else begin
      lvl_q    <= cfg_i.pol ? raw : ~raw;
      lvl_d_q  <= lvl_q;
      m_q      <= m;
      sp_act_q <= sp_act_d;
      if (!on_i)                 tff_q <= 1'b0;
      else if (lvl_q && !lvl_d_q) tff_q <= ~tff_q;
    end
  end

  assign level_o = lvl_q;
  assign open_o  = cfg_i.spm ? sp_act_q : m;
  assign done_o  = cfg_i.spm & cfg_i.go & sp_act_q & fall;
  assign event_o = cfg_i.en & fall & (~cfg_i.spm | sp_act_q);

  // R7
  tff_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> !tff_q);

  // R8
  sp_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.spm && cfg_i.go && !sp_act_q && rise) |=> sp_act_q);
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W/8-1:0] wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             inc_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int BYTES = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, wr_val;
  logic             ovf_q, any_wr, ovf_set;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign wr_val[b*8 +: 8] = wr_i[b] ? wdata_i : cnt_q[b*8 +: 8];
  end

  assign any_wr  = |wr_i;
  assign ovf_set = inc_i & ~any_wr & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (any_wr)     cnt_q <= wr_val;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      ovf_q <= ovf_set | (ovf_q & ~ovf_clr_i);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !any_wr && (&cnt_q)) |=> (ovf_q && cnt_q == '0));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !any_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
  import gt_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        ovf_clr_i,
  input  logic        gate_flag_clr_i,
  input  logic        ext_clk_i,
  input  logic        aux_clk_i,
  input  logic [3:0]  gate_src_i,
  output logic [15:0] count_o,
  output logic        gate_level_o,
  output logic        go_o,
  output logic        ovf_flag_o,
  output logic        gate_flag_o
);
  localparam int CNT_W = 16;
  localparam int BYTES = CNT_W / 8;

  ctrl_t            ctrl_q;
  gate_cfg_t        gate_q;
  logic             gflag_q;
  logic [BYTES-1:0] cnt_wr;
  logic             ctrl_wr, gate_wr;
  logic             tick, inc, cnt_en, g_open, g_event, g_done;

  assign cnt_wr[0] = wr_en_i && (wr_addr_i == A_CNT_LO);
  assign cnt_wr[1] = wr_en_i && (wr_addr_i == A_CNT_HI);
  assign ctrl_wr   = wr_en_i && (wr_addr_i == A_CTRL);
  assign gate_wr   = wr_en_i && (wr_addr_i == A_GATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      gate_q  <= '0;
      gflag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[$bits(ctrl_t)-1:0]);
      if (gate_wr)     gate_q    <= gate_cfg_t'(wr_data_i[$bits(gate_cfg_t)-1:0]);
      else if (g_done) gate_q.go <= 1'b0;
      gflag_q <= g_event | (gflag_q & ~gate_flag_clr_i);
    end
  end

  gt_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni,
    .sel_i     (ctrl_q.csel),
    .ext_clk_i,
    .aux_clk_i,
    .tick_o    (tick)
  );

  gt_gate u_gate (
    .clk_i, .rst_ni,
    .src_i   (gate_src_i),
    .cfg_i   (gate_q),
    .on_i    (ctrl_q.on),
    .level_o (gate_level_o),
    .open_o  (g_open),
    .event_o (g_event),
    .done_o  (g_done)
  );

  assign cnt_en = ctrl_q.on & (~gate_q.en | g_open);

  gt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i, .rst_ni,
    .ps_i   (ctrl_q.ps),
    .tick_i (tick),
    .en_i   (cnt_en),
    .clr_i  (|cnt_wr),
    .inc_o  (inc)
  );

  gt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .wr_i      (cnt_wr),
    .wdata_i   (wr_data_i),
    .inc_i     (inc),
    .ovf_clr_i,
    .cnt_o     (count_o),
    .ovf_o     (ovf_flag_o)
  );

  assign go_o        = gate_q.go;
  assign gate_flag_o = gflag_q;

  // R4
  no_count_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.on && cnt_wr == '0) |=> $stable(count_o));

  // R9
  gflag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gflag_q && !gate_flag_clr_i) |=> gflag_q);
endmodule

// File: tb/gated_timer16_bench.sv
module gated_timer16_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en = 0, ovf_clr = 0, gf_clr = 0, ext_clk = 0, aux_clk = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] gsrc = 0;
  logic [15:0] count;
  logic gate_level, go, ovf_flag, gate_flag;

  gated_timer16 u_gated_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ovf_clr_i(ovf_clr), .gate_flag_clr_i(gf_clr),
    .ext_clk_i(ext_clk), .aux_clk_i(aux_clk), .gate_src_i(gsrc),
    .count_o(count), .gate_level_o(gate_level), .go_o(go),
    .ovf_flag_o(ovf_flag), .gate_flag_o(gate_flag)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_cnt, m_div, m_pc, m_on, m_csel, m_ps, g_src;
  bit  m_ovf, m_gf, m_go, m_extq, m_auxq, m_lvl, m_lvld, m_tff, m_mq, m_spa;
  bit  g_en, g_pol, g_tgl, g_spm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_pc = 0; m_on = 0; m_csel = 0; m_ps = 0; g_src = 0;
      m_ovf = 0; m_gf = 0; m_go = 0; m_extq = 0; m_auxq = 0; m_lvl = 0;
      m_lvld = 0; m_tff = 0; m_mq = 0; m_spa = 0;
      g_en = 0; g_pol = 0; g_tgl = 0; g_spm = 0;
    end else begin
      bit tick, mm, rise, fall, open, en, inc, cwr, done, ev, spa_n, tff_n, lvl_n;
      int lim;
      case (m_csel)
        0: tick = (m_div == 3);
        1: tick = 1;
        2: tick = ext_clk && !m_extq;
        default: tick = aux_clk && !m_auxq;
      endcase
      mm   = g_tgl ? m_tff : m_lvl;
      rise = mm && !m_mq;
      fall = !mm && m_mq;
      open = g_spm ? m_spa : mm;
      en   = (m_on != 0) && (!g_en || open);
      lim  = (1 << m_ps) - 1;
      inc  = tick && en && (m_pc >= lim);
      cwr  = wr_en && (wr_addr <= 1);
      done = g_spm && m_go && m_spa && fall;
      ev   = g_en && fall && (!g_spm || m_spa);
      if (cwr) m_pc = 0;
      else if (tick && en) m_pc = inc ? 0 : m_pc + 1;
      if (cwr) begin
        if (wr_addr == 0) m_cnt = (m_cnt & 'hFF00) | wr_data;
        else              m_cnt = (m_cnt & 'h00FF) | (int'(wr_data) << 8);
      end else if (inc) begin
        if (m_cnt == 'hFFFF) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
        if (ovf_clr && m_cnt != 0) m_ovf = 0;
      end else if (ovf_clr) m_ovf = 0;
      m_gf  = ev || (m_gf && !gf_clr);
      spa_n = (!g_spm || !m_go) ? 0 : (m_spa && fall) ? 0 : rise ? 1 : m_spa;
      tff_n = (m_on == 0) ? 0 : (m_lvl && !m_lvld) ? !m_tff : m_tff;
      lvl_n = g_pol ? gsrc[g_src] : !gsrc[g_src];
      m_lvld = m_lvl; m_lvl = lvl_n; m_tff = tff_n; m_mq = mm; m_spa = spa_n;
      m_extq = ext_clk; m_auxq = aux_clk; m_div = (m_div + 1) % 4;
      if (wr_en && wr_addr == 3) begin
        g_en = wr_data[0]; g_pol = wr_data[1]; g_tgl = wr_data[2];
        g_spm = wr_data[3]; m_go = wr_data[4]; g_src = int'(wr_data[6:5]);
      end else if (done) m_go = 0;
      if (wr_en && wr_addr == 2) begin
        m_on = wr_data[0]; m_csel = int'(wr_data[2:1]); m_ps = int'(wr_data[4:3]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 count vs model", count, m_cnt);
      chk("R5 overflow flag vs model", ovf_flag, m_ovf);
      chk("R9 gate flag vs model", gate_flag, m_gf);
      chk("R8 go vs model", go, m_go);
      chk("R6 gate level vs model", gate_level, m_lvl);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic delta(int n, output int d);
    int s = count;
    repeat (n) @(negedge clk);
    d = (int'(count) - s) & 'hFFFF;
  endtask

  task automatic gpulse(int hi, int lo);
    gsrc[0] = 1; repeat (hi) @(negedge clk);
    gsrc[0] = 0; repeat (lo) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int d, s;
    repeat (3) @(negedge clk);
    chk("R10 reset count", count, 0);
    chk("R10 reset ovf", ovf_flag, 0);
    chk("R10 reset gate flag", gate_flag, 0);
    chk("R10 reset go", go, 0);
    rst_n = 1;
    @(negedge clk);

    wr(2, 3);  delta(8, d);  chk("R2 system clock rate", d, 8);
    wr(2, 27); delta(32, d); chk("R3 divide by 8", d, 4);
    wr(2, 11); delta(16, d); chk("R3 divide by 2", d, 8);
    wr(2, 1);  delta(40, d); chk("R2 instruction clock rate", d, 10);

    wr(2, 5); s = count;
    repeat (5) begin @(negedge clk); ext_clk = 1; @(negedge clk); ext_clk = 0; end
    repeat (2) @(negedge clk);
    chk("R2 external edges", (int'(count) - s) & 'hFFFF, 5);
    wr(2, 7); s = count;
    repeat (3) begin @(negedge clk); aux_clk = 1; @(negedge clk); aux_clk = 0; end
    repeat (2) @(negedge clk);
    chk("R2 aux edges", (int'(count) - s) & 'hFFFF, 3);

    wr(2, 2); delta(10, d); chk("R4 module off holds", d, 0);

    wr(0, 'hFD); wr(1, 'hFF);
    chk("R1 byte load", count, 'hFFFD);
    wr(2, 3); repeat (6) @(negedge clk);
    chk("R5 overflow set", ovf_flag, 1);
    chk("R5 wrapped small", count < 16, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0; @(negedge clk);
    chk("R5 overflow cleared", ovf_flag, 0);

    gsrc = 0; wr(3, 3); repeat (3) @(negedge clk);
    delta(10, d); chk("R6 gate closed", d, 0);
    chk("R6 level low", gate_level, 0);
    gsrc[0] = 1; repeat (3) @(negedge clk);
    chk("R6 level high", gate_level, 1);
    delta(10, d); chk("R6 gate open", d, 10);
    wr(3, 1); repeat (3) @(negedge clk);
    chk("R6 inverted level", gate_level, 0);
    delta(10, d); chk("R6 inverted closed", d, 0);
    gsrc = 4'b0100; wr(3, 67); repeat (3) @(negedge clk);
    delta(10, d); chk("R6 source 2 open", d, 10);

    gsrc = 0; repeat (3) @(negedge clk);
    wr(2, 2); wr(2, 3); wr(3, 7); repeat (3) @(negedge clk);
    delta(10, d); chk("R7 toggle starts closed", d, 0);
    gpulse(2, 4); delta(10, d); chk("R7 open after first edge", d, 10);
    gpulse(2, 4); delta(10, d); chk("R7 closed after second edge", d, 0);
    gpulse(2, 4); wr(2, 2); wr(2, 3); repeat (2) @(negedge clk);
    delta(10, d); chk("R7 off clears toggle", d, 0);

    wr(3, 11); repeat (3) @(negedge clk);
    gf_clr = 1; @(negedge clk); gf_clr = 0;
    wr(3, 27);
    chk("R8 go armed", go, 1);
    delta(10, d); chk("R8 armed no pulse", d, 0);
    s = count; gpulse(6, 5);
    d = (int'(count) - s) & 'hFFFF;
    chk("R8 one window counted", (d > 0 && d <= 8), 1);
    chk("R8 go cleared", go, 0);
    chk("R9 gate flag set", gate_flag, 1);
    s = count; gpulse(6, 5);
    chk("R8 no second window", (int'(count) - s) & 'hFFFF, 0);
    gf_clr = 1; @(negedge clk); gf_clr = 0; @(negedge clk);
    chk("R9 gate flag cleared", gate_flag, 0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom % 10 == 0);
      wr_addr = 2'($urandom);
      wr_data = 8'($urandom);
      if (wr_en && wr_addr == 2) wr_data[0] = 1'b1;
      if ($urandom % 5 == 0) gsrc = 4'($urandom);
      ext_clk = 1'($urandom);
      aux_clk = 1'($urandom);
      ovf_clr = ($urandom % 20 == 0);
      gf_clr  = ($urandom % 20 == 0);
    end
    @(negedge clk);
    wr_en = 0; ovf_clr = 0; gf_clr = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule